// File: doc/BRIEF.md
# Scanline and Serial-Burst Ethernet Frame Transmitter

This block turns a video scanline, a burst of queued serial-port bytes, or both, into one raw Ethernet frame. It drives that frame one byte per clock onto a GMII transmit interface that runs at 125 MHz. A request latches a row number, a frame/field number and a flag that says whether a line is included. The block then sends the following in order: the preamble and start delimiter, a fixed MAC header, a five-byte payload header, the line bytes, the queued serial bytes, zero padding and the frame check sequence. The line bytes are fetched from an external line buffer that has a registered read port. The serial bytes come from a FIFO inside the block, so characters that arrive between frames travel together in one burst and do not each cost a frame.

Because one payload header format describes both traffic types, a receiver parses every frame the same way. The flag byte tells it whether pixel data follows and how many serial bytes follow. After each frame the block keeps the transmit enable low for a minimum idle gap and only then accepts the next request.

Top module: `scanline_eth_tx`

## Requirements
- R1: Out of reset, and whenever gmii_tx_en_o is low, gmii_txd_o is 0x00, busy_o is low and uart_full_o is low.
- R2: A frame opens with seven 0x55 bytes followed by one 0xD5 byte.
- R3: After the 0xD5 byte come DST_MAC (6 bytes), SRC_MAC (6 bytes) and ETHERTYPE (2 bytes), each sent most significant byte first.
- R4: The payload begins with a 5-byte header. Byte 0 is the flag byte: bit 0 = line present, bit 1 = serial bytes present, other bits zero. Bytes 1–2 carry the row number, high byte first. Byte 3 carries the frame/field number. Byte 4 carries the serial byte count.
- R5: When the line flag is set, LINE_BYTES bytes follow the header. Byte k is the value the line buffer returns one cycle after lb_addr_o = k, for k from 0 upward.
- R6: The serial byte count is the smaller of the FIFO fill level at request time and UART_MAX_BURST. That many bytes follow the line bytes, oldest first, and any remaining bytes stay queued for a later frame.
- R7: A payload shorter than 46 bytes is extended with 0x00 bytes to exactly 46 bytes.
- R8: The last four bytes are the complement of a reflected CRC-32 (polynomial 0x04C11DB7, preset all ones) over the MAC header and payload, sent least significant byte first.
- R9: gmii_tx_en_o stays high without a break from the first preamble byte to the last check byte, and stays low for at least IFG_BYTES cycles before the next frame begins.
- R10: busy_o is high from request acceptance until the idle gap ends. A request made while busy_o is high produces no frame.
- R11: A write to the serial FIFO while uart_full_o is high is dropped and never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Frame request, accepted when busy_o is low |
| req_line_i | input | 1 | Include a scanline in the requested frame |
| req_row_i | input | 16 | Row number for the header |
| req_frame_i | input | 8 | Frame/field number for the header |
| busy_o | output | 1 | Frame or idle gap in progress |
| lb_addr_o | output | LB_AW | Line buffer read address |
| lb_data_i | input | 8 | Line buffer read data, one cycle after the address |
| uart_wr_i | input | 1 | Serial byte write strobe |
| uart_data_i | input | 8 | Serial byte to queue |
| uart_full_o | output | 1 | Serial FIFO is full |
| gmii_txd_o | output | 8 | Transmit data byte |
| gmii_tx_en_o | output | 1 | Transmit enable |

## Verification
The frame builder is exercised with several request mixes. A line-only frame shows that line fetch alignment and the header field order are correct. A serial-only frame with three bytes forces padding and shows how the count byte relates to the pad length. An over-filled FIFO feeds a line frame and then a serial-only frame, which shows the burst limit, that leftovers are kept, and that the rejected byte is dropped. An empty frame covers the all-padding case. A request made during a frame and a request made right after the previous frame separate ignoring while busy from honouring the idle gap.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

   localparam int          PRE_LEN     = 8;
   localparam int          MAC_LEN     = 14;
   localparam int          HDR_LEN     = 5;
   localparam int          FCS_LEN     = 4;
   localparam int          MIN_PAYLOAD = 46;
   localparam int          MAX_PAYLOAD = 9000;
   localparam logic [7:0]  PRE_BYTE    = 8'h55;
   localparam logic [7:0]  SFD_BYTE    = 8'hD5;
   localparam logic [31:0] CRC_POLY_RV = 32'hEDB8_8320;

   typedef enum logic [3:0] {
      ST_IDLE, ST_PRE, ST_MAC, ST_HDR, ST_LINE,
      ST_UART, ST_PAD, ST_FCS, ST_GAP
   } tx_state_e;

   // one byte through the reflected CRC-32, LSB of the byte first
   function automatic logic [31:0] crc32_next(logic [31:0] c, logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_RV) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/uart_burst_fifo.sv
module uart_burst_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [W-1:0]  din_i,
   input  logic          rd_i,
   output logic [W-1:0]  dout_o,
   output logic [CW-1:0] count_o,
   output logic          full_o
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("uart_burst_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q;
   logic [CW-1:0] cnt_q;
   logic          push, pop;

   assign full_o  = (cnt_q == CW'(DEPTH));
   assign push    = wr_i && !full_o;
   assign pop     = rd_i && (cnt_q != '0);
   assign dout_o  = mem[rptr_q];
   assign count_o = cnt_q;

   always_ff @(posedge clk) begin
      if (push) mem[wptr_q] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wptr_q <= wptr_q + AW'(1);
         if (pop)  rptr_q <= rptr_q + AW'(1);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/crc32_accum.sv
module crc32_accum
   import eth_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_i,
   input  logic        en_i,
   input  logic [7:0]  din_i,
   output logic [31:0] crc_o
);

   logic [31:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) crc_q <= '1;
      else if (en_i)       crc_q <= crc32_next(crc_q, din_i);
   end

   assign crc_o = crc_q;

endmodule

// File: rtl/scanline_eth_tx.sv
module scanline_eth_tx
   import eth_tx_pkg::*;
#(
   parameter int          LINE_BYTES     = 3072,
   parameter int          UART_DEPTH     = 16,
   parameter int          UART_MAX_BURST = 16,
   parameter int          IFG_BYTES      = 12,
   parameter logic [47:0] DST_MAC        = 48'hFF_FF_FF_FF_FF_FF,
   parameter logic [47:0] SRC_MAC        = 48'h02_00_00_00_00_01,
   parameter logic [15:0] ETHERTYPE      = 16'h88B5,
   localparam int         LB_AW          = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             req_line_i,
   input  logic [15:0]      req_row_i,
   input  logic [7:0]       req_frame_i,
   output logic             busy_o,
   output logic [LB_AW-1:0] lb_addr_o,
   input  logic [7:0]       lb_data_i,
   input  logic             uart_wr_i,
   input  logic [7:0]       uart_data_i,
   output logic             uart_full_o,
   output logic [7:0]       gmii_txd_o,
   output logic             gmii_tx_en_o
);

   localparam int CNT_W = $clog2(MAX_PAYLOAD + 1);
   localparam int UCW   = $clog2(UART_MAX_BURST + 1);
   localparam int FCW   = $clog2(UART_DEPTH) + 1;
   localparam logic [MAC_LEN*8-1:0] MAC_BITS = {DST_MAC, SRC_MAC, ETHERTYPE};

   // elaboration-time parameter checks
   if (LINE_BYTES < 1 || LINE_BYTES + HDR_LEN + UART_MAX_BURST > MAX_PAYLOAD) begin : g_bad_line
      $error("scanline_eth_tx: payload would exceed the jumbo limit");
   end
   if (UART_MAX_BURST < 1 || UART_MAX_BURST > 255) begin : g_bad_burst
      $error("scanline_eth_tx: UART_MAX_BURST must fit the one-byte count field");
   end
   if (IFG_BYTES < 12 || IFG_BYTES > 250) begin : g_bad_ifg
      $error("scanline_eth_tx: IFG_BYTES must lie in 12..250");
   end

   // ---------------- serial FIFO ----------------
   logic           f_pop, f_full;
   logic [7:0]     f_dout;
   logic [FCW-1:0] f_count;
   logic [UCW-1:0] ucnt_avail;

   uart_burst_fifo #(.DEPTH(UART_DEPTH), .W(8)) i_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (uart_wr_i),
      .din_i  (uart_data_i),
      .rd_i   (f_pop),
      .dout_o (f_dout),
      .count_o(f_count),
      .full_o (f_full)
   );

   // burst size: clamp only when the FIFO can hold more than one burst
   if (UART_MAX_BURST >= UART_DEPTH) begin : g_burst_whole
      assign ucnt_avail = UCW'(f_count);
   end else begin : g_burst_clamp
      assign ucnt_avail = (f_count > FCW'(UART_MAX_BURST)) ? UCW'(UART_MAX_BURST)
                                                           : UCW'(f_count);
   end

   // ---------------- stage 0: sequencer ----------------
   tx_state_e      state_q;
   logic [CNT_W-1:0] idx_q, plcnt_q;
   logic           line_q;
   logic [15:0]    row_q;
   logic [7:0]     frame_q;
   logic [UCW-1:0] ucnt_q;
   logic           pay_full;
   tx_state_e      tail_st;

   logic       s0_valid, s0_crc, s0_line, s0_fcs;
   logic [7:0] s0_byte;

   assign pay_full = (plcnt_q + CNT_W'(1)) >= CNT_W'(MIN_PAYLOAD);
   assign tail_st  = pay_full ? ST_FCS : ST_PAD;
   assign f_pop    = (state_q == ST_UART);
   assign lb_addr_o = idx_q[LB_AW-1:0];

   always_comb begin
      s0_valid = 1'b0;
      s0_crc   = 1'b0;
      s0_line  = 1'b0;
      s0_fcs   = 1'b0;
      s0_byte  = 8'h00;
      case (state_q)
         ST_PRE: begin
            s0_valid = 1'b1;
            s0_byte  = (idx_q == CNT_W'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
         end
         ST_MAC: begin
            s0_valid = 1'b1;
            s0_crc   = 1'b1;
            s0_byte  = MAC_BITS[(MAC_LEN - 1 - int'(idx_q[3:0])) * 8 +: 8];
         end
         ST_HDR: begin
            s0_valid = 1'b1;
            s0_crc   = 1'b1;
            case (idx_q[2:0])
               3'd0:    s0_byte = {6'b0, |ucnt_q, line_q};
               3'd1:    s0_byte = row_q[15:8];
               3'd2:    s0_byte = row_q[7:0];
               3'd3:    s0_byte = frame_q;
               default: s0_byte = 8'(ucnt_q);
            endcase
         end
         ST_LINE: begin
            s0_valid = 1'b1;
            s0_crc   = 1'b1;
            s0_line  = 1'b1;
         end
         ST_UART: begin
            s0_valid = 1'b1;
            s0_crc   = 1'b1;
            s0_byte  = f_dout;
         end
         ST_PAD: begin
            s0_valid = 1'b1;
            s0_crc   = 1'b1;
         end
         ST_FCS: begin
            s0_valid = 1'b1;
            s0_fcs   = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         plcnt_q <= '0;
         line_q  <= 1'b0;
         row_q   <= '0;
         frame_q <= '0;
         ucnt_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_i) begin
               state_q <= ST_PRE;
               idx_q   <= '0;
               plcnt_q <= '0;
               line_q  <= req_line_i;
               row_q   <= req_row_i;
               frame_q <= req_frame_i;
               ucnt_q  <= ucnt_avail;
            end
            ST_PRE: if (idx_q == CNT_W'(PRE_LEN - 1)) begin
               state_q <= ST_MAC;
               idx_q   <= '0;
            end else idx_q <= idx_q + CNT_W'(1);
            ST_MAC: if (idx_q == CNT_W'(MAC_LEN - 1)) begin
               state_q <= ST_HDR;
               idx_q   <= '0;
            end else idx_q <= idx_q + CNT_W'(1);
            ST_HDR: begin
               plcnt_q <= plcnt_q + CNT_W'(1);
               if (idx_q == CNT_W'(HDR_LEN - 1)) begin
                  idx_q   <= '0;
                  state_q <= line_q ? ST_LINE : ((|ucnt_q) ? ST_UART : tail_st);
               end else idx_q <= idx_q + CNT_W'(1);
            end
            ST_LINE: begin
               plcnt_q <= plcnt_q + CNT_W'(1);
               if (idx_q == CNT_W'(LINE_BYTES - 1)) begin
                  idx_q   <= '0;
                  state_q <= (|ucnt_q) ? ST_UART : tail_st;
               end else idx_q <= idx_q + CNT_W'(1);
            end
            ST_UART: begin
               plcnt_q <= plcnt_q + CNT_W'(1);
               if (idx_q == CNT_W'(ucnt_q) - CNT_W'(1)) begin
                  idx_q   <= '0;
                  state_q <= tail_st;
               end else idx_q <= idx_q + CNT_W'(1);
            end
            ST_PAD: begin
               plcnt_q <= plcnt_q + CNT_W'(1);
               if (pay_full) begin
                  idx_q   <= '0;
                  state_q <= ST_FCS;
               end
            end
            ST_FCS: if (idx_q == CNT_W'(FCS_LEN - 1)) begin
               state_q <= ST_GAP;
               idx_q   <= '0;
            end else idx_q <= idx_q + CNT_W'(1);
            ST_GAP: if (idx_q == CNT_W'(IFG_BYTES - 1)) begin
               state_q <= ST_IDLE;
               idx_q   <= '0;
            end else idx_q <= idx_q + CNT_W'(1);
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- stage 1: waits for line buffer data ----------------
   logic       v1, crc1, line1, fcs1;
   logic [1:0] fidx1;
   logic [7:0] byte1, d1;
   logic [31:0] crc_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         crc1  <= 1'b0;
         line1 <= 1'b0;
         fcs1  <= 1'b0;
         fidx1 <= '0;
         byte1 <= '0;
      end else begin
         v1    <= s0_valid;
         crc1  <= s0_crc;
         line1 <= s0_line;
         fcs1  <= s0_fcs;
         fidx1 <= idx_q[1:0];
         byte1 <= s0_byte;
      end
   end

   always_comb begin
      if (fcs1)       d1 = ~crc_val[int'(fidx1) * 8 +: 8];
      else if (line1) d1 = lb_data_i;
      else            d1 = byte1;
   end

   crc32_accum i_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (state_q == ST_PRE),
      .en_i  (v1 && crc1),
      .din_i (d1),
      .crc_o (crc_val)
   );

   // ---------------- stage 2: output register ----------------
   logic [7:0] txd_q;
   logic       en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txd_q <= '0;
         en_q  <= 1'b0;
      end else begin
         en_q  <= v1;
         txd_q <= v1 ? d1 : 8'h00;
      end
   end

   assign gmii_txd_o   = txd_q;
   assign gmii_tx_en_o = en_q;
   assign busy_o       = (state_q != ST_IDLE);
   assign uart_full_o  = f_full;

endmodule

// File: rtl/scanline_eth_tx_chk.sv
module scanline_eth_tx_chk #(
   parameter int IFG_BYTES = 12
)(
   input logic       clk,
   input logic       rst_n,
   input logic       busy_o,
   input logic       uart_full_o,
   input logic [7:0] gmii_txd_o,
   input logic       gmii_tx_en_o
);

   logic [7:0] gap_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                gap_cnt <= 8'(IFG_BYTES);
      else if (gmii_tx_en_o)     gap_cnt <= '0;
      else if (gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 8'd1;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !gmii_tx_en_o |-> gmii_txd_o == 8'h00);                          // R1

   AST_PREAMBLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gmii_tx_en_o) |-> gmii_txd_o == 8'h55);                    // R2

   AST_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gmii_tx_en_o) |-> gap_cnt >= 8'(IFG_BYTES));               // R9

   AST_BUSY_COVERS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      gmii_tx_en_o |-> busy_o);                                         // R10

   AST_FULL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (uart_full_o && !busy_o) |=> uart_full_o);                        // R11

endmodule

bind scanline_eth_tx scanline_eth_tx_chk #(.IFG_BYTES(IFG_BYTES)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_o       (busy_o),
   .uart_full_o  (uart_full_o),
   .gmii_txd_o   (gmii_txd_o),
   .gmii_tx_en_o (gmii_tx_en_o)
);

// File: tb/test_scanline_eth_tx.sv
module test_scanline_eth_tx;

   localparam int          LB  = 100;
   localparam int          UD  = 8;
   localparam int          UMB = 6;
   localparam int          IFG = 12;
   localparam logic [47:0] DST = 48'h02_11_22_33_44_55;
   localparam logic [47:0] SRC = 48'h02_AA_BB_CC_DD_EE;
   localparam logic [15:0] ET  = 16'h88B5;
   localparam int          AW  = $clog2(LB);

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          req = 1'b0, req_line = 1'b0;
   logic [15:0]   req_row = '0;
   logic [7:0]    req_frame = '0;
   logic          busy, full, tx_en;
   logic [AW-1:0] lb_addr;
   logic [7:0]    lb_q = '0, txd;
   logic          uwr = 1'b0;
   logic [7:0]    udata = '0;

   int n_checks = 0, n_fail = 0;

   always #5 clk = ~clk;

   scanline_eth_tx #(
      .LINE_BYTES(LB), .UART_DEPTH(UD), .UART_MAX_BURST(UMB), .IFG_BYTES(IFG),
      .DST_MAC(DST), .SRC_MAC(SRC), .ETHERTYPE(ET)
   ) i_scanline_eth_tx (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_line_i(req_line),
      .req_row_i(req_row), .req_frame_i(req_frame), .busy_o(busy),
      .lb_addr_o(lb_addr), .lb_data_i(lb_q), .uart_wr_i(uwr),
      .uart_data_i(udata), .uart_full_o(full), .gmii_txd_o(txd),
      .gmii_tx_en_o(tx_en)
   );

   function automatic logic [7:0] lb_pat(int a);
      return 8'(a * 5 + 3);
   endfunction

   // registered-read line buffer model
   always @(posedge clk) lb_q <= lb_pat(int'(lb_addr));

   // wire monitor
   logic [7:0] cap [0:4095];
   int cap_n = 0, frames = 0, low_run = 1000, last_gap = 1000;
   logic prev_en = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_en) begin
            if (!prev_en) last_gap = low_run;
            cap[cap_n] = txd;
            cap_n++;
            low_run = 0;
         end else begin
            low_run++;
            if (prev_en) frames++;
         end
         prev_en = tx_en;
      end
   end

   // software serial queue and expected frame
   logic [7:0] sq [0:63];
   int sq_n = 0;
   logic [7:0] exp_b [0:4095];
   int exp_n;
   int r_hdr, r_line, r_uart, r_pad, r_fcs;

   task automatic check(bit ok, string tag, string what, int got, int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s got %0h expected %0h", tag, what, got, expv);
      end
   endtask

   task automatic push_uart(logic [7:0] b);
      @(negedge clk);
      uwr = 1'b1; udata = b;
      @(negedge clk);
      uwr = 1'b0;
      if (sq_n < UD) begin sq[sq_n] = b; sq_n++; end
   endtask

   task automatic build(bit line, logic [15:0] row, logic [7:0] frm);
      int n, p0;
      logic [31:0] c;
      n = (sq_n < UMB) ? sq_n : UMB;
      exp_n = 0;
      for (int i = 0; i < 7; i++) begin exp_b[exp_n] = 8'h55; exp_n++; end
      exp_b[exp_n] = 8'hD5; exp_n++;
      for (int i = 5; i >= 0; i--) begin exp_b[exp_n] = DST[i*8 +: 8]; exp_n++; end
      for (int i = 5; i >= 0; i--) begin exp_b[exp_n] = SRC[i*8 +: 8]; exp_n++; end
      exp_b[exp_n] = ET[15:8]; exp_n++;
      exp_b[exp_n] = ET[7:0];  exp_n++;
      r_hdr = exp_n; p0 = exp_n;
      exp_b[exp_n] = {6'b0, n != 0, line}; exp_n++;
      exp_b[exp_n] = row[15:8]; exp_n++;
      exp_b[exp_n] = row[7:0];  exp_n++;
      exp_b[exp_n] = frm;       exp_n++;
      exp_b[exp_n] = 8'(n);     exp_n++;
      r_line = exp_n;
      if (line) for (int k = 0; k < LB; k++) begin exp_b[exp_n] = lb_pat(k); exp_n++; end
      r_uart = exp_n;
      for (int k = 0; k < n; k++) begin exp_b[exp_n] = sq[k]; exp_n++; end
      for (int k = n; k < sq_n; k++) sq[k-n] = sq[k];
      sq_n -= n;
      r_pad = exp_n;
      while (exp_n - p0 < 46) begin exp_b[exp_n] = 8'h00; exp_n++; end
      r_fcs = exp_n;
      c = 32'hFFFF_FFFF;
      for (int k = 8; k < r_fcs; k++)
         for (int b = 0; b < 8; b++)
            c = (c[0] ^ exp_b[k][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      c = ~c;
      for (int i = 0; i < 4; i++) begin exp_b[exp_n] = c[i*8 +: 8]; exp_n++; end
   endtask

   task automatic cmp_region(int base, int lo, int hi, string tag);
      bit ok = 1'b1;
      int bad = lo;
      for (int i = lo; i < hi; i++)
         if (ok && cap[base + i] !== exp_b[i]) begin ok = 1'b0; bad = i; end
      if (hi > lo)
         check(ok, tag, $sformatf("byte %0d", bad), int'(cap[base + bad]), int'(exp_b[bad]));
   endtask

   task automatic send(bit line, logic [15:0] row, logic [7:0] frm, bit poke);
      int base, f0;
      build(line, row, frm);
      @(negedge clk);
      while (busy) @(negedge clk);
      base = cap_n; f0 = frames;
      req = 1'b1; req_line = line; req_row = row; req_frame = frm;
      @(negedge clk);
      req = 1'b0;
      if (poke) begin
         repeat (20) @(negedge clk);
         req = 1'b1; req_line = 1'b0; req_row = 16'hDEAD;
         @(negedge clk);
         req = 1'b0;
      end
      wait (frames == f0 + 1);
      @(negedge clk);
      while (busy) @(negedge clk);
      check(cap_n - base == exp_n, "R9", "frame length", cap_n - base, exp_n);
      cmp_region(base, 0, 8, "R2");
      cmp_region(base, 8, r_hdr, "R3");
      cmp_region(base, r_hdr, r_line, "R4");
      cmp_region(base, r_line, r_uart, "R5");
      cmp_region(base, r_uart, r_pad, "R6");
      cmp_region(base, r_pad, r_fcs, "R7");
      cmp_region(base, r_fcs, exp_n, "R8");
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(!tx_en && txd == 8'h00 && !busy && !full, "R1", "outputs in reset",
            {tx_en, busy, full}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!tx_en && txd == 8'h00 && !busy && !full, "R1", "outputs after reset",
            {tx_en, busy, full}, 0);
   endtask

   task automatic t_line_only;
      send(1'b1, 16'h1234, 8'h05, 1'b0);    // R4 R5
   endtask

   task automatic t_uart_pad;
      push_uart(8'hC1); push_uart(8'hC2); push_uart(8'hC3);
      send(1'b0, 16'h0001, 8'h09, 1'b0);    // R6 R7
   endtask

   task automatic t_burst_full;
      for (int i = 0; i < UD; i++) push_uart(8'(8'h40 + i));
      check(full == 1'b1, "R11", "full after fill", full, 1);
      push_uart(8'hEE);                     // R11: dropped
      send(1'b1, 16'h0300, 8'h0A, 1'b0);    // R6: burst limited
      send(1'b0, 16'h0301, 8'h0B, 1'b0);    // R6 R11: leftovers, no 0xEE
      check(full == 1'b0 && sq_n == 0, "R11", "queue drained", full, 0);
   endtask

   task automatic t_empty;
      send(1'b0, 16'hFFFF, 8'hFF, 1'b0);    // R7 all padding
   endtask

   task automatic t_busy_gap;
      int f0;
      f0 = frames;
      send(1'b1, 16'h0777, 8'h21, 1'b1);    // R10 poke while busy
      repeat (40) @(negedge clk);
      check(frames == f0 + 1 && !tx_en, "R10", "frames from busy request", frames - f0, 1);
      send(1'b1, 16'h0778, 8'h22, 1'b0);    // back to back
      check(last_gap >= IFG, "R9", "idle gap", last_gap, IFG);
   endtask

   initial begin
      t_reset;
      t_line_only;
      t_uart_pad;
      t_burst_full;
      t_empty;
      t_busy_gap;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule